// File: doc/BRIEF.md
# FIFO-Level Interrupt Status Unit

This block gathers the interrupt sources of an external bus interface into one raw status word, one masked status word and one interrupt line. Two of the sources are levels: one is high while the non-blocking read FIFO holds at least a programmed number of valid entries. The other is high while the write FIFO has at least a programmed amount of free space. The other three sources are sticky event flags. They catch a bus error, the end of a read DMA and the end of a write DMA. Each stays set until software writes a one to its bit in the clear register.

Software reaches the block through a small register bus. A write is one cycle with `reg_wr_en` high. Reads are combinational from `reg_addr`. There are four word registers: raw status (read-only), mask, masked status with write-one-to-clear, and the trigger-level register. The FIFOs and DMA engines sit outside the block. They supply their counts and one-cycle completion pulses as plain inputs. No data streams through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `fifo_irq_status`

## Requirements
- R1: The raw status register at offset 0x0 places the error flag in bit 0, the read-level status in bit 1, the write-level status in bit 2, read-DMA-done in bit 3 and write-DMA-done in bit 4. Bits 31..5 read zero. A write to offset 0x0 changes no register.
- R2: After reset the mask reads 0x0 and the trigger register reads 0x20 (write code 2, read code 0). With an empty write FIFO (free count 8), the raw register reads 0x4 and `irq` is low.
- R3: Raw bit 1 is 1 exactly when the read code is 1..4 and `rd_fifo_count` is at least the threshold 1, 2, 4 or 6 (1/8, 1/4, 1/2 and 3/4 of the 8-entry depth). Code 0 and codes 5..7 force it to 0.
- R4: Raw bit 2 is 1 exactly when the write code is 1..4 and `wr_fifo_free` is at least the threshold for that code (same mapping as R3). It drops to 0 when FIFO occupancy leaves too little free space. Code 0 and codes 5..7 force it to 0.
- R5: A one-cycle pulse on `err_event`, `dma_rd_done` or `dma_wr_done` sets raw bit 0, 3 or 4 at the next clock edge. The bit stays set until a write to offset 0x8 with a 1 in that bit position. Zeros in the written word leave bits unchanged.
- R6: When an event pulse and a clearing write to its bit arrive in the same cycle, the bit ends up set.
- R7: A clearing write to offset 0x8 has no effect on the level bits 1 and 2.
- R8: The mask register at offset 0x4 stores bits 4..0 of the written word and reads back with bits 31..5 zero. A read of offset 0x8 returns the raw status ANDed with the mask.
- R9: `irq` is high exactly when at least one bit of the masked status is 1.
- R10: A read of any offset other than 0x0, 0x4, 0x8 and 0xC returns zero. A write to such an offset changes no register.
- R11: The trigger register at offset 0xC holds the read code in bits 2..0 and the write code in bits 6..4. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| rd_fifo_count | input | 4 | Valid entries in the read FIFO (0..8) |
| wr_fifo_free | input | 4 | Free entries in the write FIFO (0..8) |
| err_event | input | 1 | One-cycle pulse: bus error detected |
| dma_rd_done | input | 1 | One-cycle pulse: read DMA completed |
| dma_wr_done | input | 1 | One-cycle pulse: write DMA completed |
| irq | output | 1 | Combined interrupt, OR of the masked status |

## Verification
On every cycle the assertions check these properties: an event pulse is always visible in its flag one cycle later, even against a simultaneous clear. A set flag stays set unless its clear bit is written. A write to the raw offset leaves the flags alone. A disabled read trigger keeps the read-level bit low. Unmapped reads and the unused upper raw bits read zero. A zero mask keeps `irq` low. Some behaviour can only be shown by the bench's scenarios: the exact threshold for each trigger code across every FIFO count, the field layout of the trigger and mask readback, and the selective effect of clear words with several bits set.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int RAW_W     = 5;
  localparam int BIT_ERR   = 0;
  localparam int BIT_RDLVL = 1;
  localparam int BIT_WRLVL = 2;
  localparam int BIT_RDDMA = 3;
  localparam int BIT_WRDMA = 4;

  localparam int OFF_RAW  = 'h0;
  localparam int OFF_MASK = 'h4;
  localparam int OFF_CLR  = 'h8;
  localparam int OFF_TRIG = 'hC;

  localparam logic [2:0] RD_CODE_RST = 3'd0;
  localparam logic [2:0] WR_CODE_RST = 3'd2;

  function automatic logic trig_enabled(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

  function automatic int unsigned trig_threshold(input logic [2:0] code,
                                                 input int unsigned depth);
    case (code)
      3'd1:    return depth / 8;
      3'd2:    return depth / 4;
      3'd3:    return depth / 2;
      3'd4:    return (3 * depth) / 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fifo_irq_level.sv
module fifo_irq_level
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic [2:0]       code,
  output logic             hit
);
  always_comb begin
    hit = trig_enabled(code) && (32'(count) >= trig_threshold(code, DEPTH));
  end
endmodule

// File: rtl/fifo_irq_sticky.sv
module fifo_irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[i] <= 1'b0;
      else if (set_i[i])   flag_o[i] <= 1'b1;
      else if (clr_i[i])   flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [RAW_W-1:0]  raw,
  output logic [RAW_W-1:0]  mask_q,
  output logic [2:0]        rd_code,
  output logic [2:0]        wr_code,
  output logic [RAW_W-1:0]  clr_o
);
  logic sel_mask, sel_clr, sel_trig, sel_raw;
  logic unused_wdata;

  assign sel_raw  = (32'(addr) == OFF_RAW);
  assign sel_mask = (32'(addr) == OFF_MASK);
  assign sel_clr  = (32'(addr) == OFF_CLR);
  assign sel_trig = (32'(addr) == OFF_TRIG);
  assign unused_wdata = ^wdata[DATA_W-1:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rd_code <= RD_CODE_RST;
      wr_code <= WR_CODE_RST;
    end else if (wr_en) begin
      if (sel_mask) mask_q <= wdata[RAW_W-1:0];
      if (sel_trig) begin
        rd_code <= wdata[2:0];
        wr_code <= wdata[6:4];
      end
    end
  end

  assign clr_o = (wr_en && sel_clr) ? wdata[RAW_W-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (sel_raw)       rdata = {{(DATA_W-RAW_W){1'b0}}, raw};
    else if (sel_mask) rdata = {{(DATA_W-RAW_W){1'b0}}, mask_q};
    else if (sel_clr)  rdata = {{(DATA_W-RAW_W){1'b0}}, raw & mask_q};
    else if (sel_trig) rdata = {{(DATA_W-7){1'b0}}, wr_code, 1'b0, rd_code};
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fifo_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  rd_fifo_count,
  input  logic [CNT_W-1:0]  wr_fifo_free,
  input  logic              err_event,
  input  logic              dma_rd_done,
  input  logic              dma_wr_done,
  output logic              irq
);
  logic [RAW_W-1:0] raw_stat;
  logic [RAW_W-1:0] mask_q;
  logic [RAW_W-1:0] clr_vec;
  logic [2:0]       rd_code, wr_code;
  logic [2:0]       evt_set, evt_clr, evt_flag;
  logic [2:0]       lvl_code [2];
  logic [CNT_W-1:0] lvl_cnt  [2];
  logic [1:0]       lvl_hit;

  fifo_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .raw     (raw_stat),
    .mask_q  (mask_q),
    .rd_code (rd_code),
    .wr_code (wr_code),
    .clr_o   (clr_vec)
  );

  assign lvl_code[0] = rd_code;
  assign lvl_cnt[0]  = rd_fifo_count;
  assign lvl_code[1] = wr_code;
  assign lvl_cnt[1]  = wr_fifo_free;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    fifo_irq_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_lvl (
      .count (lvl_cnt[g]),
      .code  (lvl_code[g]),
      .hit   (lvl_hit[g])
    );
  end

  assign evt_set = {dma_wr_done, dma_rd_done, err_event};
  assign evt_clr = {clr_vec[BIT_WRDMA], clr_vec[BIT_RDDMA], clr_vec[BIT_ERR]};

  fifo_irq_sticky #(.N(3)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .flag_o (evt_flag)
  );

  always_comb begin
    raw_stat            = '0;
    raw_stat[BIT_ERR]   = evt_flag[0];
    raw_stat[BIT_RDLVL] = lvl_hit[0];
    raw_stat[BIT_WRLVL] = lvl_hit[1];
    raw_stat[BIT_RDDMA] = evt_flag[1];
    raw_stat[BIT_WRDMA] = evt_flag[2];
  end

  assign irq = |(raw_stat & mask_q);
endmodule

// File: rtl/fifo_irq_status_chk.sv
module fifo_irq_status_chk
  import fifo_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              err_event,
  input logic              dma_rd_done,
  input logic              dma_wr_done,
  input logic              irq,
  input logic [RAW_W-1:0]  raw_stat,
  input logic [RAW_W-1:0]  mask_q,
  input logic [2:0]        rd_code
);
  logic at_raw, at_clr, mapped, any_evt;
  assign at_raw  = (32'(reg_addr) == OFF_RAW);
  assign at_clr  = (32'(reg_addr) == OFF_CLR);
  assign mapped  = at_raw || at_clr || (32'(reg_addr) == OFF_MASK) || (32'(reg_addr) == OFF_TRIG);
  assign any_evt = err_event || dma_rd_done || dma_wr_done;

  AST_RAW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    at_raw |-> (reg_rdata[DATA_W-1:RAW_W] == '0)); // R1

  AST_RAW_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && at_raw && !any_evt) |=> ($stable(raw_stat[BIT_ERR]) && $stable(raw_stat[BIT_WRDMA:BIT_RDDMA]) && $stable(mask_q))); // R1

  AST_RD_TRIG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code == 3'd0 || rd_code > 3'd4) |-> !raw_stat[BIT_RDLVL]); // R3

  AST_RDDMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[BIT_RDDMA] && !(reg_wr_en && at_clr && reg_wdata[BIT_RDDMA])) |=> raw_stat[BIT_RDDMA]); // R5

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[BIT_ERR] && !(reg_wr_en && at_clr && reg_wdata[BIT_ERR])) |=> raw_stat[BIT_ERR]); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_done |=> raw_stat[BIT_WRDMA]); // R6

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> raw_stat[BIT_ERR]); // R6

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0)); // R10
endmodule

bind fifo_irq_status fifo_irq_status_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .err_event   (err_event),
  .dma_rd_done (dma_rd_done),
  .dma_wr_done (dma_wr_done),
  .irq         (irq),
  .raw_stat    (raw_stat),
  .mask_q      (mask_q),
  .rd_code     (rd_code)
);

// File: tb/tb_fifo_irq_status.sv
`timescale 1ns/1ps
module tb_fifo_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  rd_fifo_count = 4'd0;
  logic [3:0]  wr_fifo_free = 4'd8;
  logic        err_event = 1'b0, dma_rd_done = 1'b0, dma_wr_done = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_irq_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_fifo_count(rd_fifo_count),
    .wr_fifo_free(wr_fifo_free), .err_event(err_event), .dma_rd_done(dma_rd_done),
    .dma_wr_done(dma_wr_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic bit exp_hit(input int code, input int cnt);
    case (code)
      1: return cnt >= 1;
      2: return cnt >= 2;
      3: return cnt >= 4;
      4: return cnt >= 6;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R2 raw after reset", d, 32'h4);
    rd(4'h4, d); chk("R2 mask after reset", d, 32'h0);
    rd(4'hC, d); chk("R2 trig after reset", d, 32'h20);
    chk("R2 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_raw_readonly();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R1 raw unchanged by write", d, 32'h4);
    rd(4'h4, d); chk("R1 mask unchanged by raw write", d, 32'h0);
    rd(4'hC, d); chk("R1 trig unchanged by raw write", d, 32'h20);
  endtask

  task automatic t_read_level();
    logic [31:0] d;
    for (int code = 0; code < 8; code++) begin
      wr(4'hC, 32'h20 | 32'(code));
      for (int c = 0; c <= 8; c++) begin
        rd_fifo_count = 4'(c);
        rd(4'h0, d);
        chk($sformatf("R3 read level code %0d count %0d", code, c), {31'd0, d[1]}, {31'd0, exp_hit(code, c)});
      end
    end
    rd_fifo_count = 4'd0;
    wr(4'hC, 32'h20);
  endtask

  task automatic t_write_level();
    logic [31:0] d;
    for (int code = 0; code < 8; code++) begin
      wr(4'hC, 32'(code) << 4);
      for (int f = 0; f <= 8; f++) begin
        wr_fifo_free = 4'(f);
        rd(4'h0, d);
        chk($sformatf("R4 write level code %0d free %0d", code, f), {31'd0, d[2]}, {31'd0, exp_hit(code, f)});
      end
    end
    wr_fifo_free = 4'd8;
    wr(4'hC, 32'h20);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); err_event = 1'b1;
    @(negedge clk); err_event = 1'b0; dma_rd_done = 1'b1;
    @(negedge clk); dma_rd_done = 1'b0; dma_wr_done = 1'b1;
    @(negedge clk); dma_wr_done = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'h0, d); chk("R5 all events held", d, 32'h1D);
    wr(4'h8, 32'h0);
    rd(4'h0, d); chk("R5 zero clear word no effect", d, 32'h1D);
    wr(4'h8, 32'h8);
    rd(4'h0, d); chk("R5 clear read-dma only", d, 32'h15);
    wr(4'h8, 32'h6);
    rd(4'h0, d); chk("R7 clear of level bits ignored", d, 32'h15);
    wr(4'h8, 32'h11);
    rd(4'h0, d); chk("R5 clear remaining events", d, 32'h4);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    err_event = 1'b1; dma_wr_done = 1'b1;
    reg_wr_en = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h11;
    @(negedge clk);
    err_event = 1'b0; dma_wr_done = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
    rd(4'h0, d); chk("R6 set beats same-cycle clear", d, 32'h15);
    wr(4'h8, 32'h11);
    rd(4'h0, d); chk("R6 later clear works", d, 32'h4);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R8 mask readback width", d, 32'h1F);
    rd(4'h8, d); chk("R8 masked status full mask", d, 32'h4);
    #1 chk("R9 irq from write level", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h8);
    rd(4'h8, d); chk("R8 masked status bit3 only", d, 32'h0);
    #1 chk("R9 irq low when masked out", {31'd0, irq}, 32'd0);
    @(negedge clk); dma_rd_done = 1'b1;
    @(negedge clk); dma_rd_done = 1'b0;
    rd(4'h8, d); chk("R8 masked status read-dma", d, 32'h8);
    #1 chk("R9 irq from read-dma", {31'd0, irq}, 32'd1);
    wr(4'h8, 32'h8);
    #1 chk("R9 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(4'h4, 32'h4);
    @(negedge clk); wr_fifo_free = 4'd1;
    #1 chk("R9 irq follows write level", {31'd0, irq}, 32'd0);
    wr_fifo_free = 4'd8;
    wr(4'h4, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'hF, 32'hFFFF_FFFF);
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 0) begin
        rd(4'(a), d); chk($sformatf("R10 unmapped read 0x%0h", a), d, 32'h0);
      end
    end
    rd(4'h4, d); chk("R10 mask untouched", d, 32'h0);
    rd(4'hC, d); chk("R10 trig untouched", d, 32'h20);
    rd(4'h0, d); chk("R10 raw untouched", d, 32'h4);
  endtask

  task automatic t_trig_fields();
    logic [31:0] d;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R11 trig field layout", d, 32'h77);
    wr(4'hC, 32'h31);
    rd(4'hC, d); chk("R11 trig codes placed", d, 32'h31);
    wr(4'hC, 32'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw_readonly();
    t_read_level();
    t_write_level();
    t_sticky();
    t_set_wins();
    t_mask();
    t_unmapped();
    t_trig_fields();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule